// File: doc/BRIEF.md
# External Interrupt Pin Sensing Unit

This block watches a small set of external interrupt lines and turns each into a request line for the processor. Every line is first brought into the local clock domain by a two-stage synchroniser. It is then judged under its own trigger mode: level (active-high or active-low) or edge (rising, falling or both). Each line also has its own enable. Edge events are held in a per-line latch until software acknowledges them with a write-one clear. Level requests are never held: they follow the synchronised line.

All per-line controls share one configuration word, which software reads, modifies and writes back. The word has five fields of `NUM_PINS` bits each, with field `f` at bits `[f*NUM_PINS +: NUM_PINS]` and bit `i` of each field belonging to line `i`:

- field 0, ack: write-one clear of the latched edge; always reads back as zero.
- field 1, enable: the request can reach the output only while this bit is 1.
- field 2, level-select: 1 means level mode, 0 means edge mode.
- field 3, polarity: in level mode 1 means active-high and 0 means active-low; in single-edge mode 1 means rising and 0 means falling.
- field 4, dual-edge: in edge mode 1 means either edge triggers, whatever the polarity bit says.

Each line runs a two-state machine. `EV_IDLE` means no edge is held and `EV_HELD` means an edge is waiting for acknowledgement. There are three transitions:

- ARM (`EV_IDLE`→`EV_HELD`): an edge of the selected kind is seen while the line is in edge mode.
- ACK (`EV_HELD`→`EV_IDLE`): a clear is written and no new edge arrives in the same cycle.
- DROP (`EV_HELD`→`EV_IDLE`): the line is switched to level mode.

Top module: `xirq_sense`

## Requirements
- R1: Each of the four input lines drives its own request bit `irq_o[i]`. After reset every request is 0 and `cfg_rdata` reads 20'h00F00: level-select all 1, polarity, dual-edge and enable all 0.
- R2: In level mode, `irq_o[i]` equals the enable bit ANDed with (synchronised line == polarity bit). A line change reaches `irq_o` on the second rising clock edge after it is driven.
- R3: In edge mode with polarity 1 and dual-edge 0, a 0→1 transition arms the latch. `irq_o[i]` rises on the third clock edge after the line change, and a 1→0 transition arms nothing.
- R4: In edge mode with polarity 0 and dual-edge 0, a 1→0 transition arms the latch, and a 0→1 transition arms nothing.
- R5: In edge mode with dual-edge 1, either transition arms the latch, whatever the polarity bit says.
- R6: An edge is latched even while the enable bit is 0. Writing the enable bit to 1 later raises `irq_o[i]` one clock edge after the write. Writing the enable bit to 0 forces `irq_o[i]` low on the next clock edge.
- R7: Writing 1 to ack bit `i` (bit `i` of field 0) empties that line's latch on the write edge. Writing 0 there leaves the latch unchanged, and the ack field always reads back as 0.
- R8: If an edge and an ack on the same line fall on the same clock edge, the latch stays armed.
- R9: The reset trigger mode is level, active-low: once a line's enable bit is set, a low line raises its request.
- R10: `cfg_rdata` returns the last written enable, level-select, polarity and dual-edge fields at their bit positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | NUM_PINS | Asynchronous external interrupt lines |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 5*NUM_PINS | Configuration write data |
| cfg_rdata | output | 5*NUM_PINS | Configuration read data |
| irq_o | output | NUM_PINS | Per-line interrupt request |

## Verification
A latch stuck in `EV_HELD` keeps `irq_o` high after an ack, and this shows one cycle after the write. A latch that never arms leaves `irq_o` low three cycles after a qualifying edge. A wrong synchroniser depth or a wrong edge reference moves the rising request by one or more cycles, so the bench compares the output against a cycle-exact expectation on the cycle before the due cycle and on the due cycle itself. A clear that wins over a simultaneous edge shows as an immediately missing request. A polarity or mode decode error shows as a request for the wrong transition within three cycles.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
    typedef enum logic {
        EV_IDLE = 1'b0,
        EV_HELD = 1'b1
    } ev_state_e;

    localparam int FLD_ACK  = 0;
    localparam int FLD_EN   = 1;
    localparam int FLD_LVL  = 2;
    localparam int FLD_POL  = 3;
    localparam int FLD_DUAL = 4;
    localparam int NUM_FIELDS = 5;
endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
    parameter int           NUM_PINS = 4,
    parameter logic         IDLE_VAL = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    output logic [NUM_PINS-1:0] now_o,
    output logic [NUM_PINS-1:0] prev_o
);
    logic [NUM_PINS-1:0] meta_q;
    logic [NUM_PINS-1:0] now_q;
    logic [NUM_PINS-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= {NUM_PINS{IDLE_VAL}};
            now_q  <= {NUM_PINS{IDLE_VAL}};
            prev_q <= {NUM_PINS{IDLE_VAL}};
        end else begin
            meta_q <= pin_i;
            now_q  <= meta_q;
            prev_q <= now_q;
        end
    end

    assign now_o  = now_q;
    assign prev_o = prev_q;
endmodule

// File: rtl/xirq_cfg.sv
module xirq_cfg
    import xirq_pkg::*;
#(
    parameter int NUM_PINS = 4,
    localparam int CFG_W   = NUM_FIELDS * NUM_PINS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we_i,
    input  logic [CFG_W-1:0]    wdata_i,
    output logic [CFG_W-1:0]    rdata_o,
    output logic [NUM_PINS-1:0] en_o,
    output logic [NUM_PINS-1:0] lvl_o,
    output logic [NUM_PINS-1:0] pol_o,
    output logic [NUM_PINS-1:0] dual_o,
    output logic [NUM_PINS-1:0] ack_o
);
    localparam int ACK_LO  = FLD_ACK  * NUM_PINS;
    localparam int EN_LO   = FLD_EN   * NUM_PINS;
    localparam int LVL_LO  = FLD_LVL  * NUM_PINS;
    localparam int POL_LO  = FLD_POL  * NUM_PINS;
    localparam int DUAL_LO = FLD_DUAL * NUM_PINS;

    logic [NUM_PINS-1:0] en_q, lvl_q, pol_q, dual_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            lvl_q  <= '1;
            pol_q  <= '0;
            dual_q <= '0;
        end else if (we_i) begin
            en_q   <= wdata_i[EN_LO   +: NUM_PINS];
            lvl_q  <= wdata_i[LVL_LO  +: NUM_PINS];
            pol_q  <= wdata_i[POL_LO  +: NUM_PINS];
            dual_q <= wdata_i[DUAL_LO +: NUM_PINS];
        end
    end

    // ack is a pulse, only present in the write cycle
    assign ack_o = we_i ? wdata_i[ACK_LO +: NUM_PINS] : '0;

    always_comb begin
        rdata_o = '0;
        rdata_o[EN_LO   +: NUM_PINS] = en_q;
        rdata_o[LVL_LO  +: NUM_PINS] = lvl_q;
        rdata_o[POL_LO  +: NUM_PINS] = pol_q;
        rdata_o[DUAL_LO +: NUM_PINS] = dual_q;
    end

    assign en_o   = en_q;
    assign lvl_o  = lvl_q;
    assign pol_o  = pol_q;
    assign dual_o = dual_q;
endmodule

// File: rtl/xirq_chan.sv
module xirq_chan
    import xirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic now_i,
    input  logic prev_i,
    input  logic en_i,
    input  logic lvl_i,
    input  logic pol_i,
    input  logic dual_i,
    input  logic ack_i,
    output logic irq_o
);
    ev_state_e state_q, state_d;
    logic      hit;

    // edge qualifier, only meaningful in edge mode
    always_comb begin
        if (lvl_i)       hit = 1'b0;
        else if (dual_i) hit = now_i ^ prev_i;
        else if (pol_i)  hit = now_i & ~prev_i;
        else             hit = ~now_i & prev_i;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EV_IDLE: if (hit) state_d = EV_HELD;                // ARM
            EV_HELD: begin
                if (lvl_i)             state_d = EV_IDLE;       // DROP
                else if (ack_i && !hit) state_d = EV_IDLE;      // ACK
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= EV_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        if (lvl_i) irq_o = en_i & (now_i == pol_i);
        else       irq_o = en_i & (state_q == EV_HELD);
    end

    p_arm_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == EV_HELD && $past(state_q) == EV_IDLE) |-> $past(hit));

    p_hold_on_clash_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && ack_i) |=> (state_q == EV_HELD));

    p_ack_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !hit) |=> (state_q == EV_IDLE));

    p_level_no_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lvl_i) |-> (state_q == EV_IDLE));
endmodule

// File: rtl/xirq_sense.sv
module xirq_sense
    import xirq_pkg::*;
#(
    parameter int  NUM_PINS = 4,
    localparam int CFG_W    = NUM_FIELDS * NUM_PINS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic                cfg_we,
    input  logic [CFG_W-1:0]    cfg_wdata,
    output logic [CFG_W-1:0]    cfg_rdata,
    output logic [NUM_PINS-1:0] irq_o
);
    localparam int EN_LO = FLD_EN * NUM_PINS;

    logic [NUM_PINS-1:0] now_s, prev_s;
    logic [NUM_PINS-1:0] en, lvl, pol, dual, ack;

    xirq_sync #(.NUM_PINS(NUM_PINS), .IDLE_VAL(1'b1)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_i),
        .now_o  (now_s),
        .prev_o (prev_s)
    );

    xirq_cfg #(.NUM_PINS(NUM_PINS)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we),
        .wdata_i (cfg_wdata),
        .rdata_o (cfg_rdata),
        .en_o    (en),
        .lvl_o   (lvl),
        .pol_o   (pol),
        .dual_o  (dual),
        .ack_o   (ack)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_chan
        xirq_chan u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .now_i  (now_s[i]),
            .prev_i (prev_s[i]),
            .en_i   (en[i]),
            .lvl_i  (lvl[i]),
            .pol_i  (pol[i]),
            .dual_i (dual[i]),
            .ack_i  (ack[i]),
            .irq_o  (irq_o[i])
        );

        p_disable_gates_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && !cfg_wdata[EN_LO + i]) |=> !irq_o[i]);
    end
endmodule

// File: tb/test_xirq_sense.sv
module test_xirq_sense;
    localparam int N  = 4;
    localparam int CW = 5 * N;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  pin_i = '1;
    logic          cfg_we = 1'b0;
    logic [CW-1:0] cfg_wdata = '0;
    logic [CW-1:0] cfg_rdata;
    logic [N-1:0]  irq_o;

    int unsigned cyc = 0;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    typedef struct {
        int unsigned at;
        logic [N-1:0] val;
        string tag;
    } exp_t;
    exp_t sb[$];

    xirq_sense #(.NUM_PINS(N)) i_xirq_sense (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (pin_i),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .irq_o     (irq_o)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [CW-1:0] cfgw(logic [N-1:0] ack, logic [N-1:0] en,
                                           logic [N-1:0] lvl, logic [N-1:0] pol,
                                           logic [N-1:0] dual);
        return {dual, pol, lvl, en, ack};
    endfunction

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_irq(int d, logic [N-1:0] v, string tag);
        exp_t e;
        e.at = cyc + d;
        e.val = v;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic wr(logic [CW-1:0] d);
        cfg_we = 1'b1;
        cfg_wdata = d;
        tick(1);
        cfg_we = 1'b0;
        cfg_wdata = '0;
    endtask

    task automatic check_word(string tag, logic [CW-1:0] act, logic [CW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops scoreboard entries as their cycle comes due
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0 && sb[0].at <= cyc) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (e.at != cyc || irq_o !== e.val) begin
                    fails++;
                    $display("FAIL %s: actual=%b expected=%b (cycle %0d due %0d)",
                             e.tag, irq_o, e.val, cyc, e.at);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        check_word("R1 reset readback", cfg_rdata, 20'h00F00);
        check_word("R1 reset irq", {16'h0, irq_o}, 20'h0);

        // R9 default level active-low, pin 0
        wr(cfgw(4'h0, 4'hF, 4'hF, 4'h0, 4'h0));
        pin_i[0] = 1'b0;
        expect_irq(1, 4'b0000, "R2 level latency early");
        expect_irq(2, 4'b0001, "R9 active-low request");
        tick(4);
        pin_i[0] = 1'b1;
        expect_irq(2, 4'b0000, "R9 active-low release");
        tick(4);

        // R2 active-high on pin 1
        wr(cfgw(4'h0, 4'hF, 4'hF, 4'b0010, 4'h0));
        expect_irq(1, 4'b0010, "R2 active-high high line");
        tick(2);
        pin_i[1] = 1'b0;
        expect_irq(2, 4'b0000, "R2 active-high low line");
        tick(4);
        pin_i[1] = 1'b1;
        tick(4);

        // R3 rising on pin 2
        wr(cfgw(4'h0, 4'hF, 4'b1011, 4'b0100, 4'h0));
        tick(2);
        pin_i[2] = 1'b0;
        expect_irq(3, 4'b0000, "R3 falling ignored");
        tick(5);
        pin_i[2] = 1'b1;
        expect_irq(2, 4'b0000, "R3 edge latency early");
        expect_irq(3, 4'b0100, "R3 rising latched");
        tick(5);
        wr(cfgw(4'h0, 4'hF, 4'b1011, 4'b0100, 4'h0));
        expect_irq(1, 4'b0100, "R7 ack zero keeps latch");
        tick(2);
        wr(cfgw(4'b0100, 4'hF, 4'b1011, 4'b0100, 4'h0));
        check_word("R7 ack reads zero", cfg_rdata, cfgw(4'h0, 4'hF, 4'b1011, 4'b0100, 4'h0));
        expect_irq(1, 4'b0000, "R7 ack empties latch");
        tick(3);

        // R4 falling on pin 3
        wr(cfgw(4'h0, 4'hF, 4'b0111, 4'h0, 4'h0));
        tick(2);
        pin_i[3] = 1'b0;
        expect_irq(3, 4'b1000, "R4 falling latched");
        tick(5);
        wr(cfgw(4'b1000, 4'hF, 4'b0111, 4'h0, 4'h0));
        tick(2);
        pin_i[3] = 1'b1;
        expect_irq(3, 4'b0000, "R4 rising ignored");
        tick(5);

        // R5 dual edge on pin 0, polarity bit set
        wr(cfgw(4'h0, 4'hF, 4'b1110, 4'b0001, 4'b0001));
        tick(2);
        pin_i[0] = 1'b0;
        expect_irq(3, 4'b0001, "R5 dual falling");
        tick(5);
        wr(cfgw(4'b0001, 4'hF, 4'b1110, 4'b0001, 4'b0001));
        expect_irq(1, 4'b0000, "R5 ack after falling");
        tick(2);
        pin_i[0] = 1'b1;
        expect_irq(3, 4'b0001, "R5 dual rising");
        tick(5);
        wr(cfgw(4'b0001, 4'hF, 4'b1110, 4'b0001, 4'b0001));
        tick(2);

        // R6 latch while disabled, then enable
        wr(cfgw(4'h0, 4'b1110, 4'b1110, 4'b0001, 4'b0001));
        tick(2);
        pin_i[0] = 1'b0;
        expect_irq(3, 4'b0000, "R6 masked edge hidden");
        tick(6);
        wr(cfgw(4'h0, 4'hF, 4'b1110, 4'b0001, 4'b0001));
        expect_irq(1, 4'b0001, "R6 enable exposes latch");
        tick(2);
        wr(cfgw(4'h0, 4'b1110, 4'b1110, 4'b0001, 4'b0001));
        expect_irq(1, 4'b0000, "R6 disable forces low");
        tick(2);
        wr(cfgw(4'b0001, 4'hF, 4'b1110, 4'b0001, 4'b0001));
        expect_irq(1, 4'b0000, "R7 ack clears");
        tick(3);

        // R8 edge and ack on the same edge
        pin_i[0] = 1'b1;
        tick(2);
        wr(cfgw(4'b0001, 4'hF, 4'b1110, 4'b0001, 4'b0001));
        expect_irq(1, 4'b0001, "R8 clash keeps latch");
        tick(3);
        wr(cfgw(4'b0001, 4'hF, 4'b1110, 4'b0001, 4'b0001));
        expect_irq(1, 4'b0000, "R8 later ack clears");
        tick(3);

        // R10 readback of arbitrary pattern
        wr(20'hA5C3F);
        check_word("R10 readback", cfg_rdata, 20'hA5C30);
        tick(2);
        wr(cfgw(4'h0, 4'h0, 4'hF, 4'h0, 4'h0));
        check_word("R10 readback restore", cfg_rdata, 20'h00F00);
        tick(4);

        if (sb.size() != 0) begin
            fails++;
            $display("FAIL scoreboard: actual=%0d pending expected=0", sb.size());
        end
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule